// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control core of a successive-approximation ADC peripheral. It holds the main control word (input channel code, repeat-mode bit, interrupt enable and the done flag) together with the trigger-source bit. From these it decides when the attached converter starts, stops and repeats a conversion. The converter itself is outside the block. It receives a one-cycle start request with a channel code, or a one-cycle abort. It answers with a one-cycle completion pulse and a result word.

Software programs the block by presenting a new control word with a write strobe. A write always cancels any conversion still running. In software-trigger mode the same write also launches a fresh conversion, unless the channel code is the all-ones "converter off" code. In hardware-trigger mode a rising edge on the trigger pin launches the conversion instead. With repeat mode on, each completion immediately launches the next conversion on the same channel. An optional threshold compare decides whether a completion raises the done flag. A registered interrupt line mirrors the done flag while interrupts are enabled.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A control write (`ctl_wr`=1) while `active`=1 pulses `conv_abort` for one cycle on the next cycle, and a completion pulse arriving in the same cycle as a control write is discarded.
- R2: The channel code is 5 bits wide. Code 31 (all ones) starts no conversion, cancels repeat mode without one more conversion, and leaves `active`=0. Every other code, including 28, 29 and 30, is passed unchanged on `conv_chan` when a conversion starts.
- R3: With `trig_hw`=0 a control write with a code other than 31 raises `conv_req` and `active` on the next cycle. With `trig_hw`=1 a control write starts nothing, and a 0-to-1 transition on `hw_trig` raises them on the next cycle.
- R4: With `cont_en`=0 exactly one conversion runs per trigger. With `cont_en`=1 every accepted completion raises `conv_req` again on the next cycle, and `active` stays 1.
- R5: `active` becomes 1 in the cycle `conv_req` is first pulsed. It returns to 0 the cycle after a completion that does not restart, or after an abort that starts nothing.
- R6: With `cmp_en`=0 every accepted completion sets `done_flag`. With `cmp_en`=1 it is set only when `conv_result` < `cmp_val` (`cmp_gte`=0) or `conv_result` >= `cmp_val` (`cmp_gte`=1).
- R7: `done_flag` clears on the cycle after any control write, or after a low-result read strobe (`rd_low`), unless a new qualifying completion arrives in that cycle.
- R8: `irq` equals `done_flag` AND `irq_en`, delayed by one register stage.
- R9: After reset the channel code reads 31, `cont_en`, `irq_en`, `trig_hw`, `done_flag`, `active`, `irq`, `conv_req` and `conv_abort` read 0.
- R10: In hardware-trigger mode a trigger edge while `active`=1 is ignored, and a trigger held high does not start another conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-word write strobe |
| wr_chan | input | 5 | Channel code to write |
| wr_cont | input | 1 | Repeat-mode bit to write |
| wr_irq_en | input | 1 | Interrupt enable to write |
| cfg_wr | input | 1 | Trigger-source write strobe |
| cfg_trig_hw | input | 1 | Trigger source to write (1 = hardware pin) |
| hw_trig | input | 1 | Hardware trigger pin |
| rd_low | input | 1 | Strobe: low result byte is being read |
| cmp_en | input | 1 | Compare qualification enable |
| cmp_gte | input | 1 | Compare sense: 1 = greater-or-equal, 0 = less-than |
| cmp_val | input | 10 | Compare threshold |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| conv_req | output | 1 | One-cycle start request to converter |
| conv_abort | output | 1 | One-cycle abort to converter |
| conv_chan | output | 5 | Channel code for the converter |
| chan | output | 5 | Stored channel code |
| cont_en | output | 1 | Stored repeat-mode bit |
| irq_en | output | 1 | Stored interrupt enable |
| trig_hw | output | 1 | Stored trigger source |
| active | output | 1 | Conversion in progress |
| done_flag | output | 1 | Conversion complete flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the converter raises `conv_done` only while a conversion it was asked for is running, as a single-cycle pulse, and never in the cycle right after an abort with a new request. The bench meets this with a fixed-latency converter model that drops its job on `conv_abort`. Control writes are spaced so that no stale completion overlaps a restarted conversion. Hardware trigger edges are driven between clock edges, each held for at least a cycle, so that the edge detector sees a clean 0-to-1 transition.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC conversion sequencer.
// Assumes: a single clock domain; all users import this package.
package adc_seq_pkg;
    typedef enum logic {
        TRIG_SOFT = 1'b0,
        TRIG_PIN  = 1'b1
    } trig_src_e;
endpackage

// File: rtl/adc_seq_edge.sv
// Rising-edge detector for the hardware trigger pin.
// Assumes: the pin is already synchronous to clk.
module adc_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // Remember the previous pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/adc_seq_cmp.sv
// Threshold qualifier: says whether a result meets the compare condition.
// Assumes: result and threshold are unsigned and share one width.
module adc_seq_cmp #(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] result,
    input  logic [RES_W-1:0] thresh,
    input  logic             gte_mode,
    input  logic             enable,
    output logic             pass
);
    // Pass everything when disabled, otherwise apply the selected sense.
    always_comb begin
        if (!enable)       pass = 1'b1;
        else if (gte_mode) pass = (result >= thresh);
        else               pass = (result < thresh);
    end
endmodule

// File: rtl/adc_seq_irq.sv
// Registered interrupt line: flag AND enable, one cycle later, glitch free.
// Assumes: flag and enable are register outputs.
module adc_seq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic enable,
    output logic irq
);
    // Register the qualified flag.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= flag & enable;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion control sequencer: holds the control word and trigger
// source, and issues start, abort and repeat requests to a converter.
// Assumes: the converter answers a request with a single-cycle done pulse,
// and drops a job on abort. All inputs are synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic             wr_cont,
    input  logic             wr_irq_en,
    input  logic             cfg_wr,
    input  logic             cfg_trig_hw,
    input  logic             hw_trig,
    input  logic             rd_low,
    input  logic             cmp_en,
    input  logic             cmp_gte,
    input  logic [RES_W-1:0] cmp_val,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             conv_req,
    output logic             conv_abort,
    output logic [CH_W-1:0]  conv_chan,
    output logic [CH_W-1:0]  chan,
    output logic             cont_en,
    output logic             irq_en,
    output logic             trig_hw,
    output logic             active,
    output logic             done_flag,
    output logic             irq
);
    localparam logic [CH_W-1:0] CH_OFF = {CH_W{1'b1}};

    trig_src_e trig_q;
    logic      pin_rise;
    logic      cmp_pass;
    logic      done_ok;
    logic      start_soft;
    logic      start_pin;
    logic      restart;

    adc_seq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (hw_trig),
        .rise  (pin_rise)
    );

    adc_seq_cmp #(.RES_W(RES_W)) u_cmp (
        .result   (conv_result),
        .thresh   (cmp_val),
        .gte_mode (cmp_gte),
        .enable   (cmp_en),
        .pass     (cmp_pass)
    );

    adc_seq_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag   (done_flag),
        .enable (irq_en),
        .irq    (irq)
    );

    // Event decode: a control write outranks completions and pin edges.
    always_comb begin
        done_ok    = conv_done & active & ~ctl_wr;
        start_soft = ctl_wr & (trig_q == TRIG_SOFT) & (wr_chan != CH_OFF);
        start_pin  = pin_rise & (trig_q == TRIG_PIN) & ~active & ~ctl_wr
                     & (chan != CH_OFF);
        restart    = done_ok & cont_en & (chan != CH_OFF);
    end

    // Control word and trigger-source storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan    <= CH_OFF;
            cont_en <= 1'b0;
            irq_en  <= 1'b0;
            trig_q  <= TRIG_SOFT;
        end else begin
            if (ctl_wr) begin
                chan    <= wr_chan;
                cont_en <= wr_cont;
                irq_en  <= wr_irq_en;
            end
            if (cfg_wr) trig_q <= cfg_trig_hw ? TRIG_PIN : TRIG_SOFT;
        end
    end

    // Conversion sequencing: active flag and converter strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            conv_req   <= 1'b0;
            conv_abort <= 1'b0;
            conv_chan  <= CH_OFF;
        end else begin
            conv_abort <= ctl_wr & active;
            conv_req   <= start_soft | start_pin | restart;
            if (ctl_wr)         active <= start_soft;
            else if (start_pin) active <= 1'b1;
            else if (done_ok)   active <= restart;
            if (ctl_wr)         conv_chan <= wr_chan;
            else if (start_pin) conv_chan <= chan;
        end
    end

    // Done flag: set by a qualifying completion, cleared by write or read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   done_flag <= 1'b0;
        else if (ctl_wr)              done_flag <= 1'b0;
        else if (done_ok && cmp_pass) done_flag <= 1'b1;
        else if (rd_low)              done_flag <= 1'b0;
    end

    assign trig_hw = (trig_q == TRIG_PIN);
endmodule

// File: rtl/adc_seq_chk.sv
// Property checker for the ADC conversion sequencer, bound to the top.
// Assumes: conv_done is a single-cycle pulse from the converter.
module adc_seq_chk #(
    parameter int CH_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_wr,
    input logic [CH_W-1:0] wr_chan,
    input logic            conv_done,
    input logic            conv_req,
    input logic            conv_abort,
    input logic [CH_W-1:0] conv_chan,
    input logic            cont_en,
    input logic            irq_en,
    input logic            trig_hw,
    input logic            active,
    input logic            done_flag,
    input logic            irq
);
    p_abort_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && active) |=> conv_abort);

    p_off_code_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (&wr_chan)) |=> (!active && !conv_req));

    p_req_not_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> !(&conv_chan));

    p_pin_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && trig_hw) |=> !conv_req);

    p_single_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && active && !ctl_wr && !cont_en) |=> !active);

    p_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && active && !ctl_wr && cont_en) |=> (conv_req && active));

    p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !done_flag);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && irq_en) |=> irq);

    p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_flag && irq_en) |=> !irq);

    p_busy_ignores_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hw && active && !conv_done && !ctl_wr) |=> !conv_req);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .wr_chan    (wr_chan),
    .conv_done  (conv_done),
    .conv_req   (conv_req),
    .conv_abort (conv_abort),
    .conv_chan  (conv_chan),
    .cont_en    (cont_en),
    .irq_en     (irq_en),
    .trig_hw    (trig_hw),
    .active     (active),
    .done_flag  (done_flag),
    .irq        (irq)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Directed bench for the ADC conversion sequencer with a fixed-latency
// converter model.
module adc_seq_ctrl_tb_top;
    localparam int CH_W  = 5;
    localparam int RES_W = 10;
    localparam int LAT   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [CH_W-1:0]  wr_chan = '0;
    logic             wr_cont = 1'b0;
    logic             wr_irq_en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_trig_hw = 1'b0;
    logic             hw_trig = 1'b0;
    logic             rd_low = 1'b0;
    logic             cmp_en = 1'b0;
    logic             cmp_gte = 1'b0;
    logic [RES_W-1:0] cmp_val = '0;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_result = '0;
    logic             conv_req, conv_abort, cont_en, irq_en, trig_hw;
    logic             active, done_flag, irq;
    logic [CH_W-1:0]  conv_chan, chan;

    int errors = 0;
    int checks = 0;
    int reqs = 0;
    int aborts = 0;
    int dones = 0;
    int busy = 0;
    int cnt = 0;
    int cycles = 0;
    logic [RES_W-1:0] model_result = 10'd300;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_chan(wr_chan),
        .wr_cont(wr_cont), .wr_irq_en(wr_irq_en), .cfg_wr(cfg_wr),
        .cfg_trig_hw(cfg_trig_hw), .hw_trig(hw_trig), .rd_low(rd_low),
        .cmp_en(cmp_en), .cmp_gte(cmp_gte), .cmp_val(cmp_val),
        .conv_done(conv_done), .conv_result(conv_result),
        .conv_req(conv_req), .conv_abort(conv_abort), .conv_chan(conv_chan),
        .chan(chan), .cont_en(cont_en), .irq_en(irq_en), .trig_hw(trig_hw),
        .active(active), .done_flag(done_flag), .irq(irq)
    );

    // Converter model: fixed latency, job dropped on abort.
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_abort) begin
            busy = 0;
            aborts++;
        end
        if (conv_req) begin
            busy = 1;
            cnt  = LAT;
            reqs++;
        end else if (busy != 0) begin
            cnt--;
            if (cnt == 0) begin
                conv_done   <= 1'b1;
                conv_result <= model_result;
                busy = 0;
                dones++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [CH_W-1:0] c, input logic rep, input logic ie);
        ctl_wr = 1'b1; wr_chan = c; wr_cont = rep; wr_irq_en = ie;
        tick(1);
        ctl_wr = 1'b0;
    endtask

    task automatic set_trig(input logic hw);
        cfg_wr = 1'b1; cfg_trig_hw = hw;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(chan == 5'd31, "R9 chan", int'(chan), 31);
        chk({cont_en, irq_en, trig_hw} == 3'b000, "R9 mode bits", int'({cont_en, irq_en, trig_hw}), 0);
        chk({active, done_flag, irq, conv_req, conv_abort} == 5'b0, "R9 status", int'({active, done_flag, irq, conv_req, conv_abort}), 0);
    endtask

    task automatic t_single();
        int r0 = reqs;
        int d0 = dones;
        write_ctl(5'd3, 1'b0, 1'b0);
        chk(active == 1'b1, "R5 active on start", int'(active), 1);
        chk(conv_chan == 5'd3, "R3 soft start chan", int'(conv_chan), 3);
        tick(12);
        chk(reqs - r0 == 1, "R4 single conversion", reqs - r0, 1);
        chk(dones - d0 == 1, "R4 one completion", dones - d0, 1);
        chk(active == 1'b0, "R5 active clears", int'(active), 0);
        chk(done_flag == 1'b1, "R6 done set cmp off", int'(done_flag), 1);
        chk(irq == 1'b0, "R8 irq masked", int'(irq), 0);
        rd_low = 1'b1; tick(1); rd_low = 1'b0;
        chk(done_flag == 1'b0, "R7 read clears", int'(done_flag), 0);
    endtask

    task automatic t_irq();
        int r0;
        write_ctl(5'd5, 1'b0, 1'b1);
        tick(12);
        chk(irq == 1'b1, "R8 irq raised", int'(irq), 1);
        r0 = reqs;
        write_ctl(5'd31, 1'b0, 1'b1);
        chk(done_flag == 1'b0, "R7 write clears", int'(done_flag), 0);
        tick(1);
        chk(irq == 1'b0, "R8 irq follows", int'(irq), 0);
        tick(10);
        chk(reqs == r0 && active == 1'b0, "R2 off code starts nothing", reqs - r0, 0);
    endtask

    task automatic t_abort();
        int r0 = reqs;
        int a0 = aborts;
        int d0 = dones;
        write_ctl(5'd2, 1'b0, 1'b0);
        tick(2);
        write_ctl(5'd6, 1'b0, 1'b0);
        tick(1);
        chk(aborts - a0 == 1, "R1 abort pulse", aborts - a0, 1);
        chk(active == 1'b1 && conv_chan == 5'd6, "R1 restart chan", int'(conv_chan), 6);
        tick(12);
        chk(reqs - r0 == 2 && dones - d0 == 1, "R1 one completion after abort", dones - d0, 1);
        chk(done_flag == 1'b1, "R6 done after abort", int'(done_flag), 1);
    endtask

    task automatic t_cont();
        int r0 = reqs;
        int r1;
        write_ctl(5'd4, 1'b1, 1'b0);
        tick(30);
        chk(reqs - r0 >= 3, "R4 repeat conversions", reqs - r0, 3);
        chk(active == 1'b1, "R4 active in repeat", int'(active), 1);
        write_ctl(5'd31, 1'b1, 1'b0);
        r1 = reqs;
        chk(active == 1'b0, "R2 off stops repeat", int'(active), 0);
        tick(20);
        chk(reqs == r1, "R2 no extra conversion", reqs - r1, 0);
    endtask

    task automatic t_cmp();
        cmp_en = 1'b1; cmp_gte = 1'b0; cmp_val = 10'd100;
        model_result = 10'd200;
        write_ctl(5'd1, 1'b0, 1'b0);
        tick(12);
        chk(done_flag == 1'b0 && active == 1'b0, "R6 lt fails", int'(done_flag), 0);
        model_result = 10'd50;
        write_ctl(5'd1, 1'b0, 1'b0);
        tick(12);
        chk(done_flag == 1'b1, "R6 lt passes", int'(done_flag), 1);
        cmp_gte = 1'b1; model_result = 10'd100;
        write_ctl(5'd1, 1'b0, 1'b0);
        tick(12);
        chk(done_flag == 1'b1, "R6 gte equal passes", int'(done_flag), 1);
        model_result = 10'd99;
        write_ctl(5'd1, 1'b0, 1'b0);
        tick(12);
        chk(done_flag == 1'b0, "R6 gte fails", int'(done_flag), 0);
        cmp_en = 1'b0;
    endtask

    task automatic t_pin();
        int r0;
        set_trig(1'b1);
        chk(trig_hw == 1'b1, "R3 trigger source", int'(trig_hw), 1);
        r0 = reqs;
        write_ctl(5'd7, 1'b0, 1'b0);
        tick(2);
        chk(reqs == r0 && active == 1'b0, "R3 write starts nothing", reqs - r0, 0);
        hw_trig = 1'b1;
        tick(1);
        chk(active == 1'b1 && conv_chan == 5'd7, "R3 pin edge starts", int'(active), 1);
        hw_trig = 1'b0; tick(1);
        hw_trig = 1'b1; tick(12);
        chk(reqs - r0 == 1, "R10 edge while busy ignored", reqs - r0, 1);
        tick(10);
        chk(reqs - r0 == 1 && active == 1'b0, "R10 held level ignored", reqs - r0, 1);
        hw_trig = 1'b0; tick(1);
        hw_trig = 1'b1; tick(1);
        chk(reqs - r0 == 2 || active == 1'b1, "R10 fresh edge starts", int'(active), 1);
        hw_trig = 1'b0;
        tick(12);
        set_trig(1'b0);
    endtask

    task automatic t_codes();
        write_ctl(5'd29, 1'b0, 1'b0);
        chk(active == 1'b1 && conv_chan == 5'd29, "R2 reference code", int'(conv_chan), 29);
        tick(12);
        write_ctl(5'd28, 1'b0, 1'b0);
        chk(active == 1'b1 && conv_chan == 5'd28, "R2 reserved code", int'(conv_chan), 28);
        tick(12);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_single();
        t_irq();
        t_abort();
        t_cont();
        t_cmp();
        t_pin();
        t_codes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule